// File: doc/BRIEF.md
# Predicated Vector Floating-Point Max-with-Constant Unit

This block takes one wide vector value, a byte-granular predicate, an element-size code and a one-bit constant selector. It treats the vector as an array of IEEE half, single or double precision lanes. For every active lane it replaces the lane with the larger of the lane and a constant, which is either +0.0 or +1.0 at the lane's width. Lanes that are not active keep their original bits. The result is meant to be written back over the source register, so the output has the same shape as the input.

One control bit selects an alternate NaN policy. A sticky flag records any signalling NaN met in an active lane. An illegal size code raises an error flag and passes the vector through unchanged. The vector length `VLEN` is a parameter and must be a multiple of 64. Results are registered one cycle after the input strobe.

Top module: `vfm_max_imm`

## Requirements
- R1: The size code selects the lane width as 8 shifted left by the code: 01 gives 16-bit lanes, 10 gives 32-bit lanes and 11 gives 64-bit lanes. There are VLEN/width lanes, and lane e occupies bits [e*width +: width].
- R2: Size code 00 is illegal. For that code `size_err` is 1 in the registered result, `vec_out` equals `vec_in`, and `inv_sticky` does not change. For a legal code, `size_err` is 0.
- R3: With `imm_sel`=0 the constant is +0.0 (all bits zero). With `imm_sel`=1 it is +1.0: 16'h3C00, 32'h3F800000 or 64'h3FF0000000000000.
- R4: An active lane that is not a NaN becomes the numerically larger of the lane and the constant. Infinities are handled, and +0.0 ranks above -0.0, so a -0.0 lane yields +0.0.
- R5: Lane e is active exactly when predicate bit e*width/8 is 1. The other predicate bits covering that lane are ignored.
- R6: Inactive lanes appear unchanged in `vec_out`.
- R7: A NaN has an all-ones exponent and a non-zero fraction. It is signalling when the fraction MSB is 0. With `alt_nan`=0, an active signalling NaN lane yields the same bits with the fraction MSB set.
- R8: With `alt_nan`=0, an active quiet NaN lane is returned unchanged.
- R9: With `alt_nan`=1, any active NaN lane yields the constant. A signalling NaN still sets the invalid flag.
- R10: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1. `vec_out` and `size_err` update only then and otherwise hold their value.
- R11: `inv_sticky` becomes 1 in the cycle after an accepted legal-size operation that has a signalling NaN in an active lane. It then stays 1 until reset. Signalling NaNs in inactive lanes do not set it.
- R12: While `rst_n` is low, `out_valid`, `vec_out`, `size_err` and `inv_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| size_code | input | 2 | Lane width code |
| imm_sel | input | 1 | Constant select: 0 gives +0.0, 1 gives +1.0 |
| alt_nan | input | 1 | Alternate NaN policy |
| pred_in | input | VLEN/8 | Byte-granular governing predicate |
| vec_in | input | VLEN | Source vector |
| out_valid | output | 1 | Result strobe |
| vec_out | output | VLEN | Result vector |
| size_err | output | 1 | Illegal size code seen in the last operation |
| inv_sticky | output | 1 | Sticky invalid-operation flag |

## Verification
Every result (`vec_out`, `size_err`, `out_valid` and the update of `inv_sticky`) is due exactly one clock edge after the edge that samples `in_valid` high, since a single register stage lies between input and output. The bench drives inputs on the falling edge. A behavioural model, triggered by the same rising edge that loads the design's registers, computes the expected values. Outputs are compared on the next falling edge, so each operation is checked in the one cycle its result is due, and hold behaviour is checked on every idle cycle.

// File: rtl/vfm_pkg.sv
package vfm_pkg;

  typedef enum logic [1:0] {
    SZ_ILLEGAL = 2'b00,
    SZ_HALF    = 2'b01,
    SZ_SINGLE  = 2'b10,
    SZ_DOUBLE  = 2'b11
  } vfm_size_e;

  localparam int NUM_WIDTHS = 3;

  // exponent field width for an IEEE binary format of the given total width
  function automatic int exp_width(input int ew);
    case (ew)
      16:      return 5;
      32:      return 8;
      default: return 11;
    endcase
  endfunction

endpackage

// File: rtl/vfm_lane_max.sv
module vfm_lane_max #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] lane_i,
  input  logic          active_i,
  input  logic          imm_sel_i,
  input  logic          alt_nan_i,
  output logic [EW-1:0] lane_o,
  output logic          snan_o
);
  import vfm_pkg::*;

  localparam int E = exp_width(EW);
  localparam int M = EW - 1 - E;
  localparam logic [EW-1:0] ONE_VAL = {2'b00, {(E-1){1'b1}}, {M{1'b0}}};
  localparam logic [EW-1:0] QBIT    = {{(EW-M){1'b0}}, 1'b1, {(M-1){1'b0}}};

  logic [E-1:0]  exp_f;
  logic [M-1:0]  frac_f;
  logic          is_nan;
  logic          is_snan;
  logic [EW-1:0] imm_val;
  logic [EW-1:0] max_val;
  logic [EW-1:0] nan_val;

  always_comb begin
    exp_f   = lane_i[EW-2:M];
    frac_f  = lane_i[M-1:0];
    is_nan  = (&exp_f) && (|frac_f);
    is_snan = is_nan && !frac_f[M-1];
    imm_val = imm_sel_i ? ONE_VAL : '0;

    // constant is never negative: a set sign bit always loses,
    // otherwise magnitude order equals bit order
    if (lane_i[EW-1]) begin
      max_val = imm_val;
    end else if (lane_i[EW-2:0] > imm_val[EW-2:0]) begin
      max_val = lane_i;
    end else begin
      max_val = imm_val;
    end

    if (alt_nan_i) begin
      nan_val = imm_val;
    end else if (is_snan) begin
      nan_val = lane_i | QBIT;
    end else begin
      nan_val = lane_i;
    end

    if (!active_i) begin
      lane_o = lane_i;
    end else if (is_nan) begin
      lane_o = nan_val;
    end else begin
      lane_o = max_val;
    end

    snan_o = active_i && is_snan;
  end

endmodule

// File: rtl/vfm_width_slice.sv
module vfm_width_slice #(
  parameter int VLEN = 128,
  parameter int EW   = 16
) (
  input  logic [VLEN-1:0]   vec_i,
  input  logic [VLEN/8-1:0] pred_i,
  input  logic              imm_sel_i,
  input  logic              alt_nan_i,
  output logic [VLEN-1:0]   vec_o,
  output logic              inv_o
);

  localparam int NUM_LANES      = VLEN / EW;
  localparam int BYTES_PER_LANE = EW / 8;

  logic [NUM_LANES-1:0] snan_hits;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    vfm_lane_max #(.EW(EW)) u_lane (
      .lane_i    (vec_i[g*EW +: EW]),
      .active_i  (pred_i[g*BYTES_PER_LANE]),
      .imm_sel_i (imm_sel_i),
      .alt_nan_i (alt_nan_i),
      .lane_o    (vec_o[g*EW +: EW]),
      .snan_o    (snan_hits[g])
    );
  end

  assign inv_o = |snan_hits;

endmodule

// File: rtl/vfm_max_imm.sv
module vfm_max_imm #(
  parameter int VLEN = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        size_code,
  input  logic              imm_sel,
  input  logic              alt_nan,
  input  logic [VLEN/8-1:0] pred_in,
  input  logic [VLEN-1:0]   vec_in,
  output logic              out_valid,
  output logic [VLEN-1:0]   vec_out,
  output logic              size_err,
  output logic              inv_sticky
);
  import vfm_pkg::*;

  logic [VLEN-1:0]       res_w [NUM_WIDTHS];
  logic [NUM_WIDTHS-1:0] inv_w;

  // one slice per legal width: index 0 -> 16 bit, 1 -> 32, 2 -> 64
  for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
    vfm_width_slice #(.VLEN(VLEN), .EW(16 << w)) u_slice (
      .vec_i     (vec_in),
      .pred_i    (pred_in),
      .imm_sel_i (imm_sel),
      .alt_nan_i (alt_nan),
      .vec_o     (res_w[w]),
      .inv_o     (inv_w[w])
    );
  end

  logic [VLEN-1:0] vec_nxt;
  logic            err_nxt;
  logic            inv_hit;
  logic            sticky_nxt;
  logic            data_en;

  always_comb begin
    case (vfm_size_e'(size_code))
      SZ_HALF: begin
        vec_nxt = res_w[0];
        inv_hit = inv_w[0];
        err_nxt = 1'b0;
      end
      SZ_SINGLE: begin
        vec_nxt = res_w[1];
        inv_hit = inv_w[1];
        err_nxt = 1'b0;
      end
      SZ_DOUBLE: begin
        vec_nxt = res_w[2];
        inv_hit = inv_w[2];
        err_nxt = 1'b0;
      end
      default: begin
        vec_nxt = vec_in;
        inv_hit = 1'b0;
        err_nxt = 1'b1;
      end
    endcase
    data_en    = in_valid;
    sticky_nxt = inv_sticky || (in_valid && inv_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      inv_sticky <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      inv_sticky <= sticky_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out  <= '0;
      size_err <= 1'b0;
    end else if (data_en) begin
      vec_out  <= vec_nxt;
      size_err <= err_nxt;
    end
  end

endmodule

// File: rtl/vfm_max_imm_chk.sv
module vfm_max_imm_chk #(
  parameter int VLEN = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        size_code,
  input logic [VLEN/8-1:0] pred_in,
  input logic [VLEN-1:0]   vec_in,
  input logic              out_valid,
  input logic [VLEN-1:0]   vec_out,
  input logic              size_err,
  input logic              inv_sticky
);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(vec_out) && $stable(size_err)));

  a_r2_illegal_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'b00) |=> (size_err && vec_out == $past(vec_in)));

  a_r2_legal_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code != 2'b00) |=> !size_err);

  a_r2_illegal_no_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'b00 && !inv_sticky) |=> !inv_sticky);

  a_r11_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    inv_sticky |=> inv_sticky);

  a_r6_all_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_in == '0) |=> vec_out == $past(vec_in));

  a_r12_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !size_err && !inv_sticky && vec_out == '0));

endmodule

bind vfm_max_imm vfm_max_imm_chk #(.VLEN(VLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .size_code  (size_code),
  .pred_in    (pred_in),
  .vec_in     (vec_in),
  .out_valid  (out_valid),
  .vec_out    (vec_out),
  .size_err   (size_err),
  .inv_sticky (inv_sticky)
);

// File: tb/vfm_max_imm_bench.sv
`timescale 1ns/1ps
module vfm_max_imm_bench;

  localparam int VLEN = 128;
  localparam int PW   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [1:0]      size_code = 2'b01;
  logic            imm_sel = 1'b0;
  logic            alt_nan = 1'b0;
  logic [PW-1:0]   pred_in = '0;
  logic [VLEN-1:0] vec_in = '0;
  logic            out_valid;
  logic [VLEN-1:0] vec_out;
  logic            size_err;
  logic            inv_sticky;

  string cur_tag = "R12";

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  vfm_max_imm #(.VLEN(VLEN)) u_vfm_max_imm (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .size_code  (size_code),
    .imm_sel    (imm_sel),
    .alt_nan    (alt_nan),
    .pred_in    (pred_in),
    .vec_in     (vec_in),
    .out_valid  (out_valid),
    .vec_out    (vec_out),
    .size_err   (size_err),
    .inv_sticky (inv_sticky)
  );

  // ---------------- behavioural reference ----------------
  function automatic real fp_to_real(input longint unsigned ex, input longint unsigned mt,
                                     input bit sgn, input int e_w, input int m_w);
    int  bias;
    real mag;
    bias = (1 << (e_w - 1)) - 1;
    if (ex == 0) mag = real'(mt) * (2.0 ** real'(1 - bias - m_w));
    else         mag = (2.0 ** real'(m_w) + real'(mt)) * (2.0 ** real'(int'(ex) - bias - m_w));
    return sgn ? -mag : mag;
  endfunction

  function automatic void ref_lane(input logic [63:0] x, input int w, input bit sel,
                                   input bit alt, output logic [63:0] r, output bit inv);
    int e_w, m_w;
    longint unsigned ex, mt, one, imm;
    bit sgn, nan, snan;
    e_w  = (w == 16) ? 5 : (w == 32) ? 8 : 11;
    m_w  = w - 1 - e_w;
    ex   = (x >> m_w) & ((64'd1 << e_w) - 1);
    mt   = x & ((64'd1 << m_w) - 1);
    sgn  = x[w-1];
    one  = ((64'd1 << (e_w - 1)) - 1) << m_w;
    imm  = sel ? one : 64'd0;
    nan  = (ex == (64'd1 << e_w) - 1) && (mt != 0);
    snan = nan && (((mt >> (m_w - 1)) & 1) == 0);
    inv  = snan;
    if (nan) begin
      if (alt)       r = imm;
      else if (snan) r = x | (64'd1 << (m_w - 1));
      else           r = x;
    end else if (ex == (64'd1 << e_w) - 1) begin
      r = sgn ? imm : x;
    end else begin
      r = (fp_to_real(ex, mt, sgn, e_w, m_w) > (sel ? 1.0 : 0.0)) ? x : imm;
    end
  endfunction

  logic [VLEN-1:0] exp_vec;
  logic            exp_valid, exp_err, exp_sticky;
  string           exp_tag = "R12";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_vec    <= '0;
      exp_valid  <= 1'b0;
      exp_err    <= 1'b0;
      exp_sticky <= 1'b0;
      exp_tag    <= "R12";
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        logic [VLEN-1:0] acc;
        bit any_inv;
        exp_tag <= cur_tag;
        acc = '0;
        any_inv = 1'b0;
        if (size_code == 2'b00) begin
          exp_vec <= vec_in;
          exp_err <= 1'b1;
        end else begin
          int w;
          w = 8 << size_code;
          for (int e = 0; e < VLEN / w; e++) begin
            logic [VLEN-1:0] sh;
            logic [63:0] lane, res, lmask;
            bit li;
            lmask = (w == 64) ? '1 : ((64'd1 << w) - 1);
            sh    = vec_in >> (e * w);
            lane  = sh[63:0] & lmask;
            res   = lane;
            li    = 1'b0;
            if (pred_in[e * w / 8]) ref_lane(lane, w, imm_sel, alt_nan, res, li);
            any_inv = any_inv | li;
            acc = acc | (VLEN'(res & lmask) << (e * w));
          end
          exp_vec <= acc;
          exp_err <= 1'b0;
          if (any_inv) exp_sticky <= 1'b1;
        end
      end
    end
  end

  // ---------------- comparison on every falling edge ----------------
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (out_valid !== exp_valid || vec_out !== exp_vec ||
          size_err !== exp_err || inv_sticky !== exp_sticky) begin
        n_bad++;
        $display("FAIL %s t=%0t valid act=%b exp=%b vec act=%h exp=%h err act=%b exp=%b inv act=%b exp=%b",
                 exp_tag, $time, out_valid, exp_valid, vec_out, exp_vec,
                 size_err, exp_err, inv_sticky, exp_sticky);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input logic [VLEN-1:0] v, input logic [PW-1:0] p, input logic [1:0] sz,
                    input bit sel, input bit alt, input string tag);
    @(negedge clk);
    vec_in = v; pred_in = p; size_code = sz; imm_sel = sel; alt_nan = alt;
    cur_tag = tag; in_valid = 1'b1;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      cur_tag  = tag;
      vec_in   = {$urandom, $urandom, $urandom, $urandom};
      pred_in  = PW'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);               // R12 compared during reset
    rst_n = 1'b1;
    idle(2, "R12");
    // R4: mixed half values against +0.0 (1.0,-1,-0,+0,0.5,2,+inf,-inf)
    op(128'h3C00_BC00_8000_0000_3800_4000_7C00_FC00, '1, 2'b01, 1'b0, 1'b0, "R4");
    // R3: same lanes against +1.0
    op(128'h3C00_BC00_8000_0000_3800_4000_7C00_FC00, '1, 2'b01, 1'b1, 1'b0, "R3");
    // R1: single lanes, just above / below one, -0, +inf
    op(128'h3F800001_3F7FFFFF_80000000_7F800000, '1, 2'b10, 1'b1, 1'b0, "R1");
    op(128'h3F800001_3F7FFFFF_80000000_7F800000, '1, 2'b10, 1'b0, 1'b0, "R1");
    // R1: double lanes
    op(128'h3FF0000000000001_C000000000000000, '1, 2'b11, 1'b1, 1'b0, "R1");
    op(128'h0000000000000001_8000000000000000, '1, 2'b11, 1'b0, 1'b0, "R1");
    // R5: only non-lowest predicate bits set -> all half lanes inactive
    op(128'hBC00_BC00_BC00_BC00_BC00_BC00_BC00_BC00, 16'hAAAA, 2'b01, 1'b1, 1'b0, "R5");
    op(128'hBC00_BC00_BC00_BC00_BC00_BC00_BC00_BC00, 16'h5555, 2'b01, 1'b1, 1'b0, "R5");
    // R5: single lanes need bit 4*e; bits 1..3 ignored
    op(128'hBF800000_BF800000_BF800000_BF800000, 16'h0E01, 2'b10, 1'b0, 1'b0, "R5");
    // R6: some lanes inactive keep their bits
    op(128'hBC00_BC00_BC00_BC00_BC00_BC00_BC00_BC00, 16'h0101, 2'b01, 1'b1, 1'b0, "R6");
    // R11: signalling NaN in an inactive lane leaves flag clear
    op(128'h7C01_0000_0000_0000_0000_0000_0000_0000, 16'h3FFF, 2'b01, 1'b0, 1'b0, "R11");
    // R2: illegal size passes through, no flag even with signalling NaN
    op(128'h7C01_7C01_7C01_7C01_BC00_BC00_BC00_BC00, '1, 2'b00, 1'b1, 1'b0, "R2");
    idle(2, "R10");
    // R8: quiet NaN returned, no flag
    op(128'h7E00_7E55_FE00_0000_0000_0000_0000_0000, '1, 2'b01, 1'b1, 1'b0, "R8");
    // R9: alternate policy gives the constant for every NaN
    op(128'h7E00_7C01_FE00_3C00_0000_0000_0000_0000, '1, 2'b01, 1'b1, 1'b1, "R9");
    idle(1, "R9");
    // R7: signalling NaN quieted and flag set
    op(128'h7C01_FC02_0000_0000_0000_0000_0000_0000, '1, 2'b01, 1'b0, 1'b0, "R7");
    op(128'h7F800001_FFA00000_00000000_00000000, '1, 2'b10, 1'b1, 1'b0, "R7");
    // R11: flag stays set over later clean operations
    op(128'h0, '1, 2'b11, 1'b0, 1'b0, "R11");
    idle(3, "R11");
    // R10 and mixed patterns: random back-to-back and gapped traffic
    for (int k = 0; k < 400; k++) begin
      logic [VLEN-1:0] v;
      v = {$urandom, $urandom, $urandom, $urandom};
      if (($urandom % 4) == 0) v[15:0] = 16'h7C01;
      if (($urandom % 3) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        cur_tag  = "R10";
      end else begin
        op(v, PW'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), "R4");
      end
    end
    idle(2, "R10");
    // R12: reset mid-run clears everything including the sticky flag
    @(negedge clk);
    rst_n = 1'b0;
    cur_tag = "R12";
    idle(2, "R12");
    rst_n = 1'b1;
    idle(2, "R12");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule